// File: doc/BRIEF.md
# Configuration Variable Long-Form Access Engine

This block services the long-form configuration-variable access instruction in packets that already carry this decoder's address. It receives the three instruction bytes with a one-cycle strobe and a flag that tells whether the packet arrived through the consist address. From these it decodes an operation, a 10-bit variable selector and a data byte. It then runs the operation against a small internal array of 8-bit variables.

Four operations are supported: whole-byte verify, whole-byte write, single-bit verify and single-bit write. A write of either kind changes storage only when the same three bytes arrive twice in a row. A verify that matches raises a one-cycle acknowledge request, and so does a write that takes effect. The physical acknowledgement pulse and the short-form instruction are handled elsewhere.

Top module: `cv_access_engine`

## Requirements
- R1: After reset every stored variable reads 0 and `ack_req` is low. No write is pending, so the first write copy after reset does not take effect.
- R2: The upper nibble of byte 0 must be 1110 for the strobe to have any effect. Operation code 00 in bits 3:2 of byte 0 is reserved and changes nothing.
- R3: Operation code 11 writes byte 2 into the variable selected by {byte0[1:0], byte1}, where selector value e addresses CV e+1, held at slot e of `cv_contents` (bits 8e+7:8e). The write takes effect only on the second of two consecutive identical strobes. The first copy changes nothing and raises no acknowledge.
- R4: A strobe whose three bytes differ from a pending write discards that write, whatever its kind. After a write takes effect nothing stays pending, so a third identical copy counts as a new first copy.
- R5: Operation code 01 compares the selected variable with byte 2. On a match it raises the acknowledge request. On a mismatch it raises nothing. It never changes storage.
- R6: Operation code 10 is bit mode. Byte 2 bit 4 = 1 selects a bit write, byte2[2:0] gives the bit position and byte2[3] the bit value. A bit write follows the two-copy rule of R3 and alters only the addressed bit.
- R7: In bit mode with byte 2 bit 4 = 0, the request is acknowledged exactly when the addressed stored bit equals byte2[3]. Storage is unchanged.
- R8: A strobe with `via_consist` high changes no variable and raises no acknowledge.
- R9: A selector at or above the number of stored variables changes nothing and raises no acknowledge.
- R10: `ack_req` is high for exactly the one cycle after the strobe that earns it. A write's new value is visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe: the three instruction bytes are valid |
| cmd_byte0 | input | 8 | Instruction byte 0: prefix, operation code and selector bits 9:8 |
| cmd_byte1 | input | 8 | Instruction byte 1: selector bits 7:0 |
| cmd_byte2 | input | 8 | Instruction byte 2: data byte, or bit-mode control |
| via_consist | input | 1 | High when the packet came through the consist address |
| cv_contents | output | NUM_CVS*8 | Stored variables, slot e in bits 8e+7:8e |
| ack_req | output | 1 | One-cycle acknowledge request |

## Verification
Every result is registered once. After a strobe that is sampled on a rising edge, the acknowledge request and any new variable value appear during the following cycle. The bench therefore drives a one-cycle strobe from one falling edge to the next, then compares `ack_req` and every stored byte against its own model at that second falling edge. One falling edge later it confirms the acknowledge has dropped. The first copy of each write pair is checked at its own edge to show that storage has not moved.

// File: rtl/cv_access_pkg.sv
package cv_access_pkg;

    localparam logic [3:0] LONG_FORM_TAG = 4'b1110;
    localparam int         SEL_W         = 10;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_VERIFY_BYTE,
        OP_WRITE_BYTE,
        OP_VERIFY_BIT,
        OP_WRITE_BIT
    } cv_op_e;

    typedef struct packed {
        cv_op_e           op;
        logic [SEL_W-1:0] cv_sel;
        logic [7:0]       value;
        logic [2:0]       bit_pos;
        logic             bit_val;
    } cv_req_t;

    function automatic cv_req_t decode_long_form(input logic [7:0] b0,
                                                 input logic [7:0] b1,
                                                 input logic [7:0] b2);
        cv_req_t r;
        r.cv_sel  = {b0[1:0], b1};
        r.value   = b2;
        r.bit_pos = b2[2:0];
        r.bit_val = b2[3];
        r.op      = OP_NONE;
        if (b0[7:4] == LONG_FORM_TAG) begin
            unique case (b0[3:2])
                2'b01:   r.op = OP_VERIFY_BYTE;
                2'b11:   r.op = OP_WRITE_BYTE;
                2'b10:   r.op = b2[4] ? OP_WRITE_BIT : OP_VERIFY_BIT;
                default: r.op = OP_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic is_write_op(input cv_op_e op);
        return (op == OP_WRITE_BYTE) || (op == OP_WRITE_BIT);
    endfunction

endpackage

// File: rtl/cv_decode.sv
module cv_decode
    import cv_access_pkg::*;
#(
    parameter int NUM_CVS = 8
) (
    input  logic [7:0] byte0,
    input  logic [7:0] byte1,
    input  logic [7:0] byte2,
    input  logic       via_consist,
    output cv_req_t    req,
    output logic       act
);
    logic in_range;

    always_comb begin
        req      = decode_long_form(byte0, byte1, byte2);
        in_range = (32'(req.cv_sel) < NUM_CVS);
        act      = (req.op != OP_NONE) && !via_consist && in_range;
    end
endmodule

// File: rtl/cv_pair_gate.sv
module cv_pair_gate #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [WORD_W-1:0] word,
    input  logic              is_write,
    output logic              commit
);
    logic              pend_vld;
    logic [WORD_W-1:0] pend_word;

    assign commit = strobe && is_write && pend_vld && (pend_word == word);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld  <= 1'b0;
            pend_word <= '0;
        end else if (strobe) begin
            if (commit) begin
                pend_vld <= 1'b0;
            end else if (is_write) begin
                pend_vld  <= 1'b1;
                pend_word <= word;
            end else begin
                pend_vld <= 1'b0;
            end
        end
    end

    AST_FIRST_COPY_HELD: assert property (@(posedge clk) disable iff (rst)
        (strobe && is_write && !pend_vld) |=> (pend_vld && pend_word == $past(word))) // R4
        else $error("first write copy not held");

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        commit |=> !pend_vld) // R4
        else $error("pending write survived its commit");
endmodule

// File: rtl/cv_store.sv
module cv_store
    import cv_access_pkg::*;
#(
    parameter int NUM_CVS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe,
    input  logic                 act,
    input  cv_req_t              req,
    input  logic                 commit,
    output logic [NUM_CVS*8-1:0] contents,
    output logic                 ack_req
);
    localparam int IDX_W = (NUM_CVS > 1) ? $clog2(NUM_CVS) : 1;

    logic [NUM_CVS-1:0][7:0] mem;
    logic [IDX_W-1:0]        idx;
    logic [7:0]              sel_byte;
    logic                    verify_hit;

    assign idx      = req.cv_sel[IDX_W-1:0];
    assign contents = mem;

    for (genvar i = 0; i < NUM_CVS; i++) begin : g_slot
        logic [7:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (commit && (32'(idx) == i)) begin
                if (req.op == OP_WRITE_BYTE) slot_q <= req.value;
                else                         slot_q[req.bit_pos] <= req.bit_val;
            end
        end
        assign mem[i] = slot_q;
    end

    always_comb begin
        sel_byte   = mem[idx];
        verify_hit = 1'b0;
        if (strobe && act) begin
            if (req.op == OP_VERIFY_BYTE) verify_hit = (sel_byte == req.value);
            if (req.op == OP_VERIFY_BIT)  verify_hit = (sel_byte[req.bit_pos] == req.bit_val);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ack_req <= 1'b0;
        else     ack_req <= commit || verify_hit;
    end

    AST_WRITE_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !$stable(contents) |-> $past(commit)) // R3
        else $error("storage moved without a paired write");

    AST_VERIFY_INERT: assert property (@(posedge clk) disable iff (rst)
        (strobe && (req.op == OP_VERIFY_BYTE || req.op == OP_VERIFY_BIT)) |=> $stable(contents)) // R5
        else $error("verify altered storage");
endmodule

// File: rtl/cv_access_engine.sv
module cv_access_engine
    import cv_access_pkg::*;
#(
    parameter int NUM_CVS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [7:0]           cmd_byte0,
    input  logic [7:0]           cmd_byte1,
    input  logic [7:0]           cmd_byte2,
    input  logic                 via_consist,
    output logic [NUM_CVS*8-1:0] cv_contents,
    output logic                 ack_req
);
    cv_req_t req;
    logic    act;
    logic    is_write;
    logic    commit;

    cv_decode #(.NUM_CVS(NUM_CVS)) u_dec (
        .byte0       (cmd_byte0),
        .byte1       (cmd_byte1),
        .byte2       (cmd_byte2),
        .via_consist (via_consist),
        .req         (req),
        .act         (act)
    );

    assign is_write = act && is_write_op(req.op);

    cv_pair_gate #(.WORD_W(24)) u_pair (
        .clk      (clk),
        .rst      (rst),
        .strobe   (cmd_valid),
        .word     ({cmd_byte0, cmd_byte1, cmd_byte2}),
        .is_write (is_write),
        .commit   (commit)
    );

    cv_store #(.NUM_CVS(NUM_CVS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .strobe   (cmd_valid),
        .act      (act),
        .req      (req),
        .commit   (commit),
        .contents (cv_contents),
        .ack_req  (ack_req)
    );

    AST_CONSIST_INERT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && via_consist) |=> ($stable(cv_contents) && !ack_req)) // R8
        else $error("consist request acted on");

    AST_RESERVED_INERT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_byte0[3:2] == 2'b00) |=> ($stable(cv_contents) && !ack_req)) // R2
        else $error("reserved code acted on");

    AST_RANGE_INERT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && 32'({cmd_byte0[1:0], cmd_byte1}) >= NUM_CVS)
        |=> ($stable(cv_contents) && !ack_req)) // R9
        else $error("out-of-range selector acted on");

    AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        ack_req |-> $past(cmd_valid)) // R10
        else $error("acknowledge without a strobe");
endmodule

// File: tb/sim_cv_access_engine.sv
module sim_cv_access_engine;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cmd_valid = 1'b0;
    logic [7:0]     cmd_byte0 = '0, cmd_byte1 = '0, cmd_byte2 = '0;
    logic           via_consist = 1'b0;
    logic [N*8-1:0] cv_contents;
    logic           ack_req;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    logic [7:0] model [N];

    always #5 clk = ~clk;

    cv_access_engine #(.NUM_CVS(N)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid),
        .cmd_byte0(cmd_byte0), .cmd_byte1(cmd_byte1), .cmd_byte2(cmd_byte2),
        .via_consist(via_consist), .cv_contents(cv_contents), .ack_req(ack_req)
    );

    function automatic logic [7:0] hdr(input logic [1:0] gg, input logic [9:0] sel);
        return {4'b1110, gg, sel[9:8]};
    endfunction

    task automatic send(input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] c, input logic cons);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte0 = a; cmd_byte1 = b; cmd_byte2 = c; via_consist = cons;
        @(negedge clk);
        cmd_valid = 1'b0; via_consist = 1'b0;
    endtask

    task automatic expect_state(input string tag, input logic exp_ack);
        logic [N*8-1:0] exp;
        for (int k = 0; k < N; k++) exp[k*8 +: 8] = model[k];
        checks++;
        if (ack_req !== exp_ack || cv_contents !== exp) begin
            fails++;
            $display("FAIL %s: ack=%0b contents=%h, expected ack=%0b contents=%h",
                     tag, ack_req, cv_contents, exp_ack, exp);
        end
    endtask

    task automatic wr_byte(input int sel, input logic [7:0] v, input logic cons);
        send(hdr(2'b11, 10'(sel)), 8'(sel), v, cons);
    endtask

    initial begin
        for (int k = 0; k < N; k++) model[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_state("R1 reset", 1'b0);

        // R1: first copy after reset only arms the pair
        wr_byte(0, 8'h77, 1'b0);
        expect_state("R1 first copy after reset", 1'b0);
        wr_byte(0, 8'h77, 1'b0);
        model[0] = 8'h77;
        expect_state("R3 pair after reset", 1'b1);

        // R3 / R10: byte write sweep over every slot
        for (int i = 0; i < N; i++) begin
            logic [7:0] v;
            v = 8'(i * 29 + 3);
            wr_byte(i, v, 1'b0);
            expect_state("R3 first copy holds", 1'b0);
            wr_byte(i, v, 1'b0);
            model[i] = v;
            expect_state("R3 second copy commits", 1'b1);
            @(negedge clk);
            expect_state("R10 ack lasts one cycle", 1'b0);
        end

        // R5: byte verify, matching and mismatching
        for (int i = 0; i < N; i++) begin
            send(hdr(2'b01, 10'(i)), 8'(i), model[i], 1'b0);
            expect_state("R5 verify match", 1'b1);
            send(hdr(2'b01, 10'(i)), 8'(i), model[i] ^ 8'h5a, 1'b0);
            expect_state("R5 verify mismatch", 1'b0);
        end

        // R6 / R7: bit write and bit verify over every slot and position
        for (int i = 0; i < N; i++) begin
            for (int p = 0; p < 8; p++) begin
                logic nv;
                nv = ~model[i][p];
                send(hdr(2'b10, 10'(i)), 8'(i), {3'b000, 1'b1, nv, 3'(p)}, 1'b0);
                expect_state("R6 bit write first copy", 1'b0);
                send(hdr(2'b10, 10'(i)), 8'(i), {3'b000, 1'b1, nv, 3'(p)}, 1'b0);
                model[i][p] = nv;
                expect_state("R6 bit write commits", 1'b1);
                send(hdr(2'b10, 10'(i)), 8'(i), {3'b000, 1'b0, nv, 3'(p)}, 1'b0);
                expect_state("R7 bit verify match", 1'b1);
                send(hdr(2'b10, 10'(i)), 8'(i), {3'b000, 1'b0, ~nv, 3'(p)}, 1'b0);
                expect_state("R7 bit verify mismatch", 1'b0);
            end
        end

        // R4: an intervening write discards the pending one
        wr_byte(2, 8'hA1, 1'b0);
        wr_byte(3, 8'hB2, 1'b0);
        expect_state("R4 other write is a first copy", 1'b0);
        wr_byte(2, 8'hA1, 1'b0);
        expect_state("R4 discarded pair does not commit", 1'b0);
        wr_byte(2, 8'hA1, 1'b0);
        model[2] = 8'hA1;
        expect_state("R4 fresh pair commits", 1'b1);
        // R4: an intervening verify discards too
        wr_byte(1, 8'hE5, 1'b0);
        send(hdr(2'b01, 10'd1), 8'd1, model[1], 1'b0);
        expect_state("R4 verify between copies", 1'b1);
        wr_byte(1, 8'hE5, 1'b0);
        expect_state("R4 verify discarded pending", 1'b0);
        // R4: third identical copy starts a new pair
        wr_byte(5, 8'hC3, 1'b0);
        wr_byte(5, 8'hC3, 1'b0);
        model[5] = 8'hC3;
        expect_state("R4 pair commits", 1'b1);
        wr_byte(5, 8'hC3, 1'b0);
        expect_state("R4 third copy no ack", 1'b0);
        wr_byte(5, 8'h3C, 1'b0);
        wr_byte(5, 8'h3C, 1'b0);
        model[5] = 8'h3C;
        expect_state("R4 next pair commits", 1'b1);

        // R8: consist-routed requests are refused
        wr_byte(4, 8'hF0, 1'b1);
        wr_byte(4, 8'hF0, 1'b1);
        expect_state("R8 consist write refused", 1'b0);
        send(hdr(2'b01, 10'd4), 8'd4, model[4], 1'b1);
        expect_state("R8 consist verify refused", 1'b0);
        wr_byte(4, 8'hF0, 1'b0);
        send(hdr(2'b11, 10'd4), 8'd4, 8'hF0, 1'b1);
        wr_byte(4, 8'hF0, 1'b0);
        expect_state("R8 consist strobe discards pending", 1'b0);

        // R2: reserved code and wrong prefix
        send(hdr(2'b00, 10'd6), 8'd6, 8'h99, 1'b0);
        send(hdr(2'b00, 10'd6), 8'd6, 8'h99, 1'b0);
        expect_state("R2 reserved code ignored", 1'b0);
        send(8'b1100_1100, 8'd6, 8'h99, 1'b0);
        send(8'b1100_1100, 8'd6, 8'h99, 1'b0);
        expect_state("R2 wrong prefix ignored", 1'b0);
        send(8'b0110_0100, 8'd6, model[6], 1'b0);
        expect_state("R2 wrong prefix verify ignored", 1'b0);

        // R9: selectors beyond the array
        wr_byte(N, 8'h11, 1'b0);
        wr_byte(N, 8'h11, 1'b0);
        expect_state("R9 selector N ignored", 1'b0);
        wr_byte(1023, 8'h22, 1'b0);
        wr_byte(1023, 8'h22, 1'b0);
        expect_state("R9 selector 1023 ignored", 1'b0);
        send(hdr(2'b01, 10'd256), 8'd0, model[0], 1'b0);
        expect_state("R9 aliased high selector ignored", 1'b0);

        @(negedge clk);
        expect_state("R10 idle ack low", 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule